// File: doc/BRIEF.md
# Per-Processor Control Register Block with Redirected Window

This block holds a small private register set for each virtual processor (VP) in a multi-processor cluster. Every bus access carries the ID of the VP that issues it. Accesses to the local window reach the requester's own register copy. Accesses to the remote window reach the copy of whichever VP the requester has named in its own redirect register. One VP can therefore inspect or program any other VP through the same offsets it uses for itself.

Each VP has a boot-vector register that holds the address where that VP starts fetching after its next reset. The register is 4 KiB aligned, and its value is driven out continuously as one vector per VP. A read-only configuration register reports the number of VPs. Writes take effect in one cycle. Read data comes back registered, one cycle after the request.

Top module: `vp_ctl_regs`

## Requirements
- R1: While reset is asserted and after it is released, every boot vector equals 0xBFC00000, every redirect register reads 0, and the read data is 0.
- R2: An address with bit 13 set and bit 14 clear selects the local window, which accesses the registers of the VP given by the requester ID. Other VPs' copies stay unchanged.
- R3: An address with bit 14 set and bit 13 clear selects the remote window, which accesses the registers of the VP whose index is held in the requester's own redirect register. This includes the case where that index is the requester itself.
- R4: The redirect register sits at offset 0x18. Only bits 2:0 store data (the VP index), and bits 31:3 always read 0.
- R5: The boot-vector register sits at offset 0x20. It stores bits 31:12, and bits 11:0 always read 0 whatever value is written.
- R6: A boot-vector write does not change that VP's vector output before the clock edge that captures it. The output shows the new value immediately after that edge.
- R7: The configuration register at offset 0x10 reads the VP count minus one in bits 2:0 and ignores writes.
- R8: Offsets within a window other than 0x10, 0x18 and 0x20 read 0 and ignore writes. The same holds for addresses where bits 14 and 13 are both set or both clear. Only address bits 7:0 form the offset.
- R9: Suppose a remote-window access names a VP index at or above the VP count, or a local-window access comes from a requester ID at or above the count. Then the access reads 0, and a write to it changes no register or vector output.
- R10: Read data appears one cycle after a read request. It is 0 in the cycle after any cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_req_id | input | 3 | ID of the requesting VP |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| boot_vec | output | NUM_VP*DATA_W (128) | Boot vectors, VP i in bits [i*32 +: 32] |

## Verification
The redirect path and the requester's own local path can land on the same register copy. This happens when a VP names itself in its redirect register, and it also happens when a remote write from one VP targets the copy that the owning VP then reads locally. The bench provokes both cases. It sets a self-redirect and writes through the remote window, then reads the value back through the local window. It also writes VP 1's boot vector from VP 0 and has VP 1 read it. In each case the bench compares the read against the masked value it expects. It also compares the boot-vector output just before and just after the capturing edge.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
   localparam int unsigned IDX_W = 3;
   localparam logic [7:0] OFS_CFG = 8'h10;
   localparam logic [7:0] OFS_RDR = 8'h18;
   localparam logic [7:0] OFS_BOOT = 8'h20;

   typedef enum logic [1:0] {
      WIN_NONE  = 2'd0,
      WIN_LOCAL = 2'd1,
      WIN_REMOTE = 2'd2
   } win_e;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CFG  = 2'd1,
      SEL_RDR  = 2'd2,
      SEL_BOOT = 2'd3
   } sel_e;
endpackage

// File: rtl/vpr_win_decode.sv
module vpr_win_decode
   import vpr_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output win_e              win,
   output sel_e              rsel
);
   if (ADDR_W < 15) begin : g_bad_addr
      $error("vpr_win_decode: ADDR_W must be at least 15");
   end

   always_comb begin
      unique case ({addr[14], addr[13]})
         2'b01:   win = WIN_LOCAL;
         2'b10:   win = WIN_REMOTE;
         default: win = WIN_NONE;
      endcase
   end

   always_comb begin
      rsel = SEL_NONE;
      if (win != WIN_NONE) begin
         unique case (addr[7:0])
            OFS_CFG:  rsel = SEL_CFG;
            OFS_RDR:  rsel = SEL_RDR;
            OFS_BOOT: rsel = SEL_BOOT;
            default:  rsel = SEL_NONE;
         endcase
      end
   end
endmodule

// File: rtl/vpr_route.sv
module vpr_route
   import vpr_pkg::*;
#(
   parameter int unsigned NUM_VP = 4
) (
   input  logic [IDX_W-1:0]        req_id,
   input  win_e                    win,
   input  logic [NUM_VP*IDX_W-1:0] rdr_flat,
   output logic [IDX_W-1:0]        tgt,
   output logic                    tgt_ok
);
   logic [IDX_W-1:0] own_rdr;
   logic             req_ok;

   always_comb begin
      own_rdr = '0;
      for (int i = 0; i < NUM_VP; i++) begin
         if (int'(req_id) == i) own_rdr = rdr_flat[i*IDX_W +: IDX_W];
      end
   end

   assign req_ok = int'(req_id) < NUM_VP;
   assign tgt    = (win == WIN_REMOTE) ? own_rdr : req_id;
   assign tgt_ok = req_ok && (win != WIN_NONE) && (int'(tgt) < NUM_VP);
endmodule

// File: rtl/vpr_vp_bank.sv
module vpr_vp_bank
   import vpr_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned VEC_LSB = 12,
   parameter logic [DATA_W-1:0] RST_VEC = 32'hBFC0_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_rdr,
   input  logic               we_boot,
   input  logic [DATA_W-1:0]  wdata,
   output logic [IDX_W-1:0]   rdr_q,
   output logic [DATA_W-1:0]  boot_q
);
   localparam int unsigned KEEP_W = DATA_W - VEC_LSB;

   logic [KEEP_W-1:0] base_q;

   if (VEC_LSB == 0 || VEC_LSB >= DATA_W) begin : g_bad_align
      $error("vpr_vp_bank: VEC_LSB must lie in 1..DATA_W-1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdr_q  <= '0;
         base_q <= RST_VEC[DATA_W-1:VEC_LSB];
      end else begin
         if (we_rdr)  rdr_q  <= wdata[IDX_W-1:0];
         if (we_boot) base_q <= wdata[DATA_W-1:VEC_LSB];
      end
   end

   assign boot_q = {base_q, {VEC_LSB{1'b0}}};

   // R6
   boot_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_q != $past(boot_q)) |-> $past(we_boot));
endmodule

// File: rtl/vp_ctl_regs.sv
module vp_ctl_regs
   import vpr_pkg::*;
#(
   parameter int unsigned NUM_VP  = 4,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned VEC_LSB = 12,
   parameter logic [DATA_W-1:0] RST_VEC = 32'hBFC0_0000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_valid,
   input  logic                     bus_write,
   input  logic [IDX_W-1:0]         bus_req_id,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   output logic [NUM_VP*DATA_W-1:0] boot_vec
);
   localparam logic [DATA_W-1:0] CFG_VAL = DATA_W'(NUM_VP - 1);

   if (NUM_VP < 1 || NUM_VP > 8) begin : g_bad_count
      $error("vp_ctl_regs: NUM_VP must lie in 1..8");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("vp_ctl_regs: DATA_W must be at least 8");
   end

   win_e                    win;
   sel_e                    rsel;
   logic [IDX_W-1:0]        tgt;
   logic                    tgt_ok;
   logic [NUM_VP*IDX_W-1:0] rdr_flat;
   logic [DATA_W-1:0]       boot_arr [NUM_VP];
   logic [NUM_VP-1:0]       we_rdr_v, we_boot_v;
   logic                    wr_go, rd_go;
   logic [DATA_W-1:0]       rd_nxt, rdata_q;
   logic [IDX_W-1:0]        tgt_rdr;
   logic [DATA_W-1:0]       tgt_boot;

   vpr_win_decode #(.ADDR_W(ADDR_W)) dec_i (
      .addr (bus_addr),
      .win  (win),
      .rsel (rsel)
   );

   vpr_route #(.NUM_VP(NUM_VP)) route_i (
      .req_id   (bus_req_id),
      .win      (win),
      .rdr_flat (rdr_flat),
      .tgt      (tgt),
      .tgt_ok   (tgt_ok)
   );

   assign wr_go = bus_valid &&  bus_write && tgt_ok;
   assign rd_go = bus_valid && !bus_write && tgt_ok;

   for (genvar g = 0; g < NUM_VP; g++) begin : g_vp
      assign we_rdr_v[g]  = wr_go && (int'(tgt) == g) && (rsel == SEL_RDR);
      assign we_boot_v[g] = wr_go && (int'(tgt) == g) && (rsel == SEL_BOOT);

      vpr_vp_bank #(
         .DATA_W  (DATA_W),
         .VEC_LSB (VEC_LSB),
         .RST_VEC (RST_VEC)
      ) bank_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_rdr  (we_rdr_v[g]),
         .we_boot (we_boot_v[g]),
         .wdata   (bus_wdata),
         .rdr_q   (rdr_flat[g*IDX_W +: IDX_W]),
         .boot_q  (boot_arr[g])
      );

      assign boot_vec[g*DATA_W +: DATA_W] = boot_arr[g];
   end

   always_comb begin
      tgt_rdr  = '0;
      tgt_boot = '0;
      for (int i = 0; i < NUM_VP; i++) begin
         if (int'(tgt) == i) begin
            tgt_rdr  = rdr_flat[i*IDX_W +: IDX_W];
            tgt_boot = boot_arr[i];
         end
      end
   end

   always_comb begin
      rd_nxt = '0;
      if (rd_go) begin
         unique case (rsel)
            SEL_CFG:  rd_nxt = CFG_VAL;
            SEL_RDR:  rd_nxt = DATA_W'(tgt_rdr);
            SEL_BOOT: rd_nxt = tgt_boot;
            default:  rd_nxt = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rd_nxt;
   end

   assign bus_rdata = rdata_q;

   // R10
   idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_valid && !bus_write) |-> (bus_rdata == '0));

   // R9
   bad_target_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_valid && !tgt_ok) |-> (bus_rdata == '0));

   // R5
   boot_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_go && rsel == SEL_BOOT) |-> (bus_rdata[VEC_LSB-1:0] == '0));

   // R4
   rdr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_go && rsel == SEL_RDR) |-> (bus_rdata[DATA_W-1:IDX_W] == '0));

   // R2
   one_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({we_rdr_v, we_boot_v}));
endmodule

// File: tb/vp_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module vp_ctl_regs_tb_top;
   localparam int NV = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_valid = 1'b0;
   logic              bus_write = 1'b0;
   logic [2:0]        bus_req_id = '0;
   logic [15:0]       bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NV*32-1:0]  boot_vec;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vp_ctl_regs #(.NUM_VP(NV)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_valid  (bus_valid),
      .bus_write  (bus_write),
      .bus_req_id (bus_req_id),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .boot_vec   (boot_vec)
   );

   typedef struct packed {
      logic        wr;
      logic [2:0]  id;
      logic [15:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NVEC = 21;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 3'd0, 16'h2020, 32'h0, 32'hBFC0_0000, 8'd1},  // R1
      '{1'b0, 3'd2, 16'h2018, 32'h0, 32'h0,         8'd1},  // R1
      '{1'b0, 3'd1, 16'h2010, 32'h0, 32'h3,         8'd7},  // R7
      '{1'b1, 3'd1, 16'h2020, 32'h1234_5678, 32'h0, 8'd5},
      '{1'b0, 3'd1, 16'h2020, 32'h0, 32'h1234_5000, 8'd5},  // R5
      '{1'b0, 3'd0, 16'h2020, 32'h0, 32'hBFC0_0000, 8'd2},  // R2
      '{1'b1, 3'd0, 16'h2018, 32'hFFFF_FFF9, 32'h0, 8'd4},
      '{1'b0, 3'd0, 16'h2018, 32'h0, 32'h1,         8'd4},  // R4
      '{1'b0, 3'd0, 16'h4020, 32'h0, 32'h1234_5000, 8'd3},  // R3
      '{1'b1, 3'd0, 16'h4020, 32'h8000_0FFF, 32'h0, 8'd3},
      '{1'b0, 3'd1, 16'h2020, 32'h0, 32'h8000_0000, 8'd3},  // R3
      '{1'b1, 3'd0, 16'h2010, 32'hFFFF_FFFF, 32'h0, 8'd7},
      '{1'b0, 3'd0, 16'h2010, 32'h0, 32'h3,         8'd7},  // R7
      '{1'b1, 3'd2, 16'h2024, 32'hFFFF_FFFF, 32'h0, 8'd8},
      '{1'b0, 3'd2, 16'h2024, 32'h0, 32'h0,         8'd8},  // R8
      '{1'b0, 3'd2, 16'h6020, 32'h0, 32'h0,         8'd8},  // R8
      '{1'b1, 3'd2, 16'h6020, 32'h0000_7000, 32'h0, 8'd8},
      '{1'b0, 3'd2, 16'h2020, 32'h0, 32'hBFC0_0000, 8'd8},  // R8
      '{1'b1, 3'd3, 16'h2018, 32'h6, 32'h0,         8'd9},
      '{1'b0, 3'd3, 16'h4020, 32'h0, 32'h0,         8'd9},  // R9
      '{1'b1, 3'd3, 16'h4020, 32'h1111_1000, 32'h0, 8'd9}
   };

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] id, input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_req_id = id; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [2:0] id, input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_req_id = id; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      // R1: state during reset
      check("R1 vectors in reset", boot_vec, {4{32'hBFC0_0000}});
      check("R1 rdata in reset", bus_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rdata after reset", bus_rdata, 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         if (VECS[i].wr) wr(VECS[i].id, VECS[i].addr, VECS[i].data);
         else begin
            rd(VECS[i].id, VECS[i].addr, r);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), r, VECS[i].exp);
         end
      end

      // R9 and R8: ignored writes left every vector as set by the table
      check("R9 vectors untouched", boot_vec,
            {32'hBFC0_0000, 32'hBFC0_0000, 32'h8000_0000, 32'hBFC0_0000});

      // R9: local read from a requester ID beyond the count
      rd(3'd5, 16'h2010, r);
      check("R9 bad requester read", r, 32'h0);

      // R3: self redirect, remote write seen in the local window
      wr(3'd2, 16'h2018, 32'h2);
      wr(3'd2, 16'h4020, 32'h0000_3ABC);
      rd(3'd2, 16'h2020, r);
      check("R3 self redirect", r, 32'h0000_3000);

      // R10: cycle after a write has zero read data
      wr(3'd1, 16'h2018, 32'h0);
      check("R10 rdata after write", bus_rdata, 32'h0);

      // R6: vector timing around the capturing edge
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_req_id = 3'd3;
      bus_addr = 16'h2020; bus_wdata = 32'h00AB_C123;
      #1;
      check("R6 before edge", boot_vec[3*32 +: 32], 32'hBFC0_0000);
      @(posedge clk);
      #1;
      check("R6 after edge", boot_vec[3*32 +: 32], 32'h00AB_C000);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;

      // R2: only VP 3 changed
      check("R2 other copies", boot_vec[3*32-1:0],
            {32'h0000_3000, 32'h8000_0000, 32'hBFC0_0000});

      // R1: reset again restores defaults
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check("R1 vectors after re-reset", boot_vec, {4{32'hBFC0_0000}});
      rd(3'd2, 16'h2018, r);
      check("R1 redirect after re-reset", r, 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule